// File: doc/BRIEF.md
# DRAM Address-Map Configuration Matcher

This block picks which of sixteen fixed DRAM address-map layouts suits a memory whose geometry is already known. The caller gives the column count, the row count, whether the data bus is 32 or 16 bits wide, and which address-interleave scheme it wants. The block returns the lowest table index whose entry belongs to that scheme and meets that scheme's matching rule, or it reports that no entry fits.

A one-cycle start pulse, taken while the block is idle, samples all inputs. The block then tests one table entry per clock cycle in ascending order. It stops at the first hit, or after the last entry. A one-cycle done pulse marks the result. The index and no-match outputs keep that result until the next done. All pins are plain control and status levels. No data stream crosses the boundary, so no valid/ready handshake is needed. A start that arrives while a scan is running is dropped, and the caller is expected to wait for done.

Top module: `amap_matcher`

## Requirements
- R1: The column count used for matching equals `col_in` when `bus_is32` is 1. When `bus_is32` is 0 it equals `col_in` minus one, and a zero stays zero.
- R2: `scheme` encodes 0 = column-bank-row-device, 1 = column-row-bank-device, 2 = column-bank-device-row. Code 3 never matches. Entries that belong to a scheme other than the selected one are skipped.
- R3: Scheme 0 hits an entry only when both its columns and its rows equal the request exactly.
- R4: Scheme 1 hits an entry when its columns equal the request and its rows are less than or equal to the requested rows.
- R5: Scheme 2 hits an entry when its columns equal the request. It also hits when its columns are at most the requested columns and its rows equal the requested rows.
- R6: Entries are tested in ascending index order, one per cycle, and the lowest hit wins. Count the edge that samples start as edge 1. A hit on entry i raises `done` after edge i+2. A miss raises `done` after edge 17.
- R7: When no entry hits, `done` comes with `no_match` = 1 and `map_idx` = 0. A hit comes with `no_match` = 0.
- R8: `done` lasts exactly one cycle. `map_idx` and `no_match` change only together with `done` and hold until the next `done`.
- R9: A start pulse during a scan (`busy` = 1) is ignored. Inputs are sampled only at an accepted start, so later changes on them do not affect the running scan.
- R10: After reset, `busy`, `done`, `no_match` and `map_idx` are all 0.
- R11: Table contents as (scheme, rows, cols):
  - Entries 0-3: scheme 0, rows 13-16, cols 10.
  - Entries 4-6: scheme 0, rows 14-16, cols 11.
  - Entries 7-10: scheme 0, rows 13-16, cols 9.
  - Entries 11, 12, 13: scheme 1, (15,10), (14,11), (13,10).
  - Entries 14, 15: scheme 2, (16,10), (16,9).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse, accepted only while idle |
| col_in | input | COL_W (4) | Detected column address bits |
| row_in | input | ROW_W (5) | Detected row address bits |
| bus_is32 | input | 1 | 1 = 32-bit bus, 0 = 16-bit bus |
| scheme | input | 2 | Selected interleave scheme code |
| busy | output | 1 | Scan in progress |
| done | output | 1 | One-cycle result pulse |
| map_idx | output | IDX_W (4) | Index of the winning entry |
| no_match | output | 1 | No entry satisfied the rule |

## Verification
The bound checker watches several properties on every cycle:
- `done` is a single-cycle pulse.
- An accepted start always raises `busy` on the following cycle.
- The result outputs move only together with `done`.
- A miss always reports index 0.
- Scheme code 3 never yields a hit.
- No scan lasts longer than the table.

The per-scheme matching rules, the bus-width column adjustment, lowest-index priority and exact latency are shown only by the scoreboard scenarios. The same holds for the immunity of a running scan to input changes and to a second start. Those scenarios compare each result against an independent table model.

// File: rtl/amap_pkg.sv
package amap_pkg;

  localparam int TBL_N     = 16;
  localparam int TBL_ROW_W = 5;
  localparam int TBL_COL_W = 4;

  typedef enum logic [1:0] {
    SCH_CBRD = 2'd0,
    SCH_CRBD = 2'd1,
    SCH_CBDR = 2'd2,
    SCH_NONE = 2'd3
  } sched_e;

  typedef struct packed {
    sched_e                 sch;
    logic [TBL_ROW_W-1:0]   rows;
    logic [TBL_COL_W-1:0]   cols;
  } map_ent_t;

  // Computed table contents; indices past the defined range never match.
  function automatic map_ent_t ent_at(input int unsigned k);
    map_ent_t e;
    e.sch  = SCH_NONE;
    e.rows = '0;
    e.cols = '0;
    if (k < 4) begin
      e.sch  = SCH_CBRD;
      e.rows = TBL_ROW_W'(13 + k);
      e.cols = TBL_COL_W'(10);
    end else if (k < 7) begin
      e.sch  = SCH_CBRD;
      e.rows = TBL_ROW_W'(14 + (k - 4));
      e.cols = TBL_COL_W'(11);
    end else if (k < 11) begin
      e.sch  = SCH_CBRD;
      e.rows = TBL_ROW_W'(13 + (k - 7));
      e.cols = TBL_COL_W'(9);
    end else begin
      case (k)
        11: begin e.sch = SCH_CRBD; e.rows = TBL_ROW_W'(15); e.cols = TBL_COL_W'(10); end
        12: begin e.sch = SCH_CRBD; e.rows = TBL_ROW_W'(14); e.cols = TBL_COL_W'(11); end
        13: begin e.sch = SCH_CRBD; e.rows = TBL_ROW_W'(13); e.cols = TBL_COL_W'(10); end
        14: begin e.sch = SCH_CBDR; e.rows = TBL_ROW_W'(16); e.cols = TBL_COL_W'(10); end
        15: begin e.sch = SCH_CBDR; e.rows = TBL_ROW_W'(16); e.cols = TBL_COL_W'(9);  end
        default: ;
      endcase
    end
    return e;
  endfunction

endpackage

// File: rtl/amap_table.sv
module amap_table
  import amap_pkg::*;
#(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic [IDX_W-1:0] sel_idx,
  output map_ent_t         ent
);

  map_ent_t rom [N];

  for (genvar g = 0; g < N; g++) begin : g_rom
    assign rom[g] = ent_at(g);
  end

  assign ent = rom[sel_idx];

endmodule

// File: rtl/amap_rule.sv
module amap_rule
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5
) (
  input  map_ent_t         ent,
  input  sched_e           sel,
  input  logic [COL_W-1:0] col,
  input  logic [ROW_W-1:0] row,
  output logic             hit
);

  logic [COL_W-1:0] tc;
  logic [ROW_W-1:0] tr;
  logic col_eq, col_le, row_eq, row_le;

  always_comb begin
    tc     = COL_W'(ent.cols);
    tr     = ROW_W'(ent.rows);
    col_eq = (tc == col);
    col_le = (tc <= col);
    row_eq = (tr == row);
    row_le = (tr <= row);
    hit    = 1'b0;
    if (ent.sch == sel) begin
      unique case (sel)
        SCH_CBRD: hit = col_eq && row_eq;
        SCH_CRBD: hit = col_eq && row_le;
        SCH_CBDR: hit = col_eq || (col_le && row_eq);
        default:  hit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/amap_scan.sv
module amap_scan #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             hit,
  output logic             accept,
  output logic             busy,
  output logic [IDX_W-1:0] ptr,
  output logic             done,
  output logic [IDX_W-1:0] res_idx,
  output logic             res_none
);

  localparam logic [IDX_W-1:0] LAST = IDX_W'(N - 1);

  assign accept = start && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      ptr      <= '0;
      done     <= 1'b0;
      res_idx  <= '0;
      res_none <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        busy <= 1'b1;
        ptr  <= '0;
      end else if (busy) begin
        if (hit) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          res_idx  <= ptr;
          res_none <= 1'b0;
        end else if (ptr == LAST) begin
          busy     <= 1'b0;
          done     <= 1'b1;
          res_idx  <= '0;
          res_none <= 1'b1;
        end else begin
          ptr <= ptr + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/amap_matcher.sv
module amap_matcher
  import amap_pkg::*;
#(
  parameter int COL_W = 4,
  parameter int ROW_W = 5,
  parameter int N     = TBL_N,
  localparam int IDX_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [COL_W-1:0] col_in,
  input  logic [ROW_W-1:0] row_in,
  input  logic             bus_is32,
  input  logic [1:0]       scheme,
  output logic             busy,
  output logic             done,
  output logic [IDX_W-1:0] map_idx,
  output logic             no_match
);

  logic [COL_W-1:0] col_eff, col_q;
  logic [ROW_W-1:0] row_q;
  sched_e           sch_q;
  logic             accept, hit;
  logic [IDX_W-1:0] ptr;
  map_ent_t         ent;

  // A 16-bit bus consumes one column address bit.
  always_comb begin
    if (bus_is32)            col_eff = col_in;
    else if (col_in == '0)   col_eff = '0;
    else                     col_eff = col_in - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      col_q <= '0;
      row_q <= '0;
      sch_q <= SCH_NONE;
    end else if (accept) begin
      col_q <= col_eff;
      row_q <= row_in;
      sch_q <= sched_e'(scheme);
    end
  end

  amap_table #(.N(N), .IDX_W(IDX_W)) u_tbl (
    .sel_idx (ptr),
    .ent     (ent)
  );

  amap_rule #(.COL_W(COL_W), .ROW_W(ROW_W)) u_rule (
    .ent (ent),
    .sel (sch_q),
    .col (col_q),
    .row (row_q),
    .hit (hit)
  );

  amap_scan #(.N(N), .IDX_W(IDX_W)) u_scan (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .hit      (hit),
    .accept   (accept),
    .busy     (busy),
    .ptr      (ptr),
    .done     (done),
    .res_idx  (map_idx),
    .res_none (no_match)
  );

endmodule

// File: rtl/amap_matcher_chk.sv
module amap_matcher_chk #(
  parameter int N     = 16,
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic [1:0]       scheme,
  input logic             busy,
  input logic             done,
  input logic [IDX_W-1:0] map_idx,
  input logic             no_match
);

  logic [1:0] sch_seen;
  logic [IDX_W:0] scan_cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sch_seen <= 2'd0;
      scan_cnt <= '0;
    end else if (start && !busy) begin
      sch_seen <= scheme;
      scan_cnt <= '0;
    end else if (busy) begin
      scan_cnt <= scan_cnt + 1'b1;
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(map_idx) || !$stable(no_match)) |-> done); // R8

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (busy && !done)); // R9

  AST_MISS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (done && no_match) |-> (map_idx == '0)); // R7

  AST_CODE3_NOHIT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && (sch_seen == 2'd3)) |-> no_match); // R2

  AST_SCAN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (scan_cnt < (IDX_W+1)'(N))); // R6

endmodule

bind amap_matcher amap_matcher_chk #(.N(N), .IDX_W(IDX_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .scheme   (scheme),
  .busy     (busy),
  .done     (done),
  .map_idx  (map_idx),
  .no_match (no_match)
);

// File: tb/sim_amap_matcher.sv
module sim_amap_matcher;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] col_in = '0;
  logic [4:0] row_in = '0;
  logic       bus_is32 = 1'b1;
  logic [1:0] scheme = '0;
  logic       busy, done, no_match;
  logic [3:0] map_idx;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit finished = 0;

  int    q_idx[$];
  bit    q_nf[$];
  int    q_t0[$];
  string q_tag[$];
  int    last_idx = 0;
  bit    last_nf  = 0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  amap_matcher u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .col_in(col_in), .row_in(row_in),
    .bus_is32(bus_is32), .scheme(scheme), .busy(busy), .done(done),
    .map_idx(map_idx), .no_match(no_match)
  );

  // Independent model of the table (R11) and rules (R1-R5)
  localparam int TR [16] = '{13,14,15,16,14,15,16,13,14,15,16,15,14,13,16,16};
  localparam int TC [16] = '{10,10,10,10,11,11,11, 9, 9, 9, 9,10,11,10,10, 9};
  localparam int TS [16] = '{ 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1, 1, 2, 2};

  function automatic void model(input int c, input int r, input bit w, input int s,
                                output int idx, output bit nf);
    int ce;
    bit m;
    ce  = w ? c : ((c == 0) ? 0 : c - 1);
    idx = 0;
    nf  = 1;
    for (int k = 0; k < 16; k++) begin
      m = 0;
      if (TS[k] == s) begin
        if (s == 0) m = (TC[k] == ce) && (TR[k] == r);
        if (s == 1) m = (TC[k] == ce) && (TR[k] <= r);
        if (s == 2) m = (TC[k] == ce) || ((TC[k] <= ce) && (TR[k] == r));
      end
      if (m && nf) begin idx = k; nf = 0; end
    end
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic run(input int c, input int r, input bit w, input int s, input string tag);
    int ei;
    bit en;
    model(c, r, w, s, ei, en);
    @(negedge clk);
    col_in = c[3:0]; row_in = r[4:0]; bus_is32 = w; scheme = s[1:0]; start = 1'b1;
    q_idx.push_back(ei); q_nf.push_back(en); q_t0.push_back(cyc); q_tag.push_back(tag);
    @(negedge clk);
    start = 1'b0;
    repeat (22) @(negedge clk);
    chk(map_idx == 4'(last_idx), "R8", "held index", map_idx, last_idx);
  endtask

  // Monitor: pops expected results as done pulses appear
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done) begin
        if (q_idx.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          int ei, t0, lat;
          bit en;
          string tg;
          ei = q_idx.pop_front(); en = q_nf.pop_front();
          t0 = q_t0.pop_front();  tg = q_tag.pop_front();
          lat = en ? 17 : ei + 2;
          chk(map_idx == 4'(ei), tg, "index", map_idx, ei);
          chk(no_match == en, (en ? "R7" : tg), "no_match", no_match, en);
          chk((cyc - t0) == lat, "R6", "latency", cyc - t0, lat);
          last_idx = ei; last_nf = en;
        end
      end
    end
  end

  task automatic summary;
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(0, "WDOG", "watchdog expired", cyc, 0);
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0 && no_match == 0 && map_idx == 0, "R10", "reset outputs",
        {busy, done, no_match, map_idx}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    // scheme 0, exact (R3)
    run(10, 13, 1, 0, "R3");
    run(11, 16, 1, 0, "R3");
    run( 9, 16, 1, 0, "R3");
    run(10, 12, 1, 0, "R3");
    run(12, 13, 1, 0, "R3");
    // bus width adjustment (R1)
    run(11, 14, 0, 0, "R1");
    run(12, 16, 0, 2, "R1");
    run( 0, 16, 0, 2, "R1");
    // scheme 1, at-least rows (R4)
    run(10, 16, 1, 1, "R4");
    run(10, 13, 1, 1, "R4");
    run(11, 14, 1, 1, "R4");
    run(11, 13, 1, 1, "R4");
    // scheme 2, fallback (R5)
    run(10, 12, 1, 2, "R5");
    run( 9, 13, 1, 2, "R5");
    run(11, 16, 1, 2, "R5");
    run(11, 15, 1, 2, "R5");
    // unused code and skipping (R2), lowest index (R6), table (R11)
    run(10, 13, 1, 3, "R2");
    run(10, 15, 1, 1, "R11");
    run(16 - 1, 16, 1, 0, "R7");

    // R9: second start and input changes during a scan are ignored
    begin
      int ei;
      bit en;
      model(9, 16, 1, 0, ei, en);
      @(negedge clk);
      col_in = 4'd9; row_in = 5'd16; bus_is32 = 1; scheme = 2'd0; start = 1'b1;
      q_idx.push_back(ei); q_nf.push_back(en); q_t0.push_back(cyc); q_tag.push_back("R9");
      @(negedge clk);
      start = 1'b0; col_in = 4'd10; row_in = 5'd13;
      repeat (3) @(negedge clk);
      start = 1'b1; scheme = 2'd2;
      @(negedge clk);
      start = 1'b0;
      repeat (24) @(negedge clk);
      chk(map_idx == 4'(ei), "R9", "result after ignored start", map_idx, ei);
    end

    chk(q_idx.size() == 0, "R6", "missing results", q_idx.size(), 0);
    summary();
  end

endmodule